// File: doc/BRIEF.md
# Masked PC Breakpoint Comparator Bank

This block watches the program counter of a processor and flags when it reaches an address that a debugger has marked. It holds four breakpoint addresses. The first one (the primary breakpoint) works with a 32-bit ignore-mask, so it can match a whole range or pattern of addresses. The other three (the secondary breakpoints) match one address exactly, and each one is armed by its own valid bit.

A debugger writes the registers through a write-only port made of a strobe, a 5-bit register index and 32 data bits. In every cycle that the PC input is marked valid, the bank compares that PC against all four entries. One cycle later it reports a registered hit vector with one bit per breakpoint, and the OR of that vector. A per-comparator enable input acts as the external trigger setting. A comparator can only report a hit while its enable input is high.

Top module: `pcbk_bank`

## Requirements
- R1: After reset, every breakpoint address, every valid bit and the mask are zero, and `hit` and `any_hit` are low. The primary entry therefore matches any PC whose bits 31..1 are zero, and no secondary entry can hit.
- R2: A write to index 0x08 loads the primary entry. Index 0x09 loads the mask. Indices 0x18, 0x1A and 0x1B load secondary entries 1, 2 and 3, which report on `hit[1]`, `hit[2]` and `hit[3]`. The primary entry reports on `hit[0]`.
- R3: The primary entry compares PC bits 31..1 with its stored bits 31..1. A stored mask bit of 1 excludes that bit position from the comparison, and a 0 includes it. PC bit 0 never takes part in any comparison.
- R4: The primary entry has no valid bit. Bit 0 of its write data is discarded, and the entry is armed by `cmp_en[0]` alone.
- R5: In a secondary write, data bit 0 is the valid bit and bits 31..1 are the address. A secondary entry hits only when its valid bit is 1 and all of PC bits 31..1 are equal to its address. The mask has no effect on it.
- R6: `hit[i]` is registered. It is 1 in the cycle after a sample in which `pc_vld` was high, entry i matched and `cmp_en[i]` was high. Otherwise it is 0.
- R7: `any_hit` equals the OR of the four `hit` bits in the same cycle.
- R8: A write to any index other than the five listed changes no stored state.
- R9: A PC sampled in the same cycle as a register write is compared against the contents from before that write. The new contents take effect from the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 5 | Register index for the write |
| wr_data | input | 32 | Write data |
| pc | input | 32 | Current program counter |
| pc_vld | input | 1 | PC sample qualifier |
| cmp_en | input | 4 | Per-comparator enable (external trigger setting) |
| hit | output | 4 | Registered per-breakpoint hit |
| any_hit | output | 1 | OR of `hit` |

## Verification
The hardest case to reach from the ports is a primary match that happens only because of the mask. It needs a mask that ignores exactly the bit position where the PC differs from the stored address. The bench sweeps a single set mask bit across all 31 address positions. At each position it presents a PC that differs only in that bit, and then repeats the sample with the mask cleared, so each position must turn the hit on and then off again. Stale state after ignored writes and same-cycle write/compare overlap are also only visible through later samples. The bench therefore sends every unlisted index an all-ones write, and it lines up one write with a sample in the same cycle.

// File: rtl/pcbk_bank.sv
module pcbk_bank #(
  parameter int AW = 32,
  parameter logic [4:0] IDX_PRI = 5'h08,
  parameter logic [4:0] IDX_MSK = 5'h09,
  parameter logic [4:0] IDX_S1  = 5'h18,
  parameter logic [4:0] IDX_S2  = 5'h1A,
  parameter logic [4:0] IDX_S3  = 5'h1B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [4:0]    wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic [AW-1:0] pc,
  input  logic          pc_vld,
  input  logic [3:0]    cmp_en,
  output logic [3:0]    hit,
  output logic          any_hit
);
  localparam int NSEC = 3;

  logic [AW-1:1] pri_q;
  logic [AW-1:1] msk_q;
  logic [AW-1:1] sec_q [NSEC];
  logic [NSEC-1:0] sec_v;
  logic [NSEC-1:0] sec_sel;
  logic [3:0] match;

  logic unused_bits;
  assign unused_bits = pc[0];

  assign sec_sel[0] = wr_en && wr_idx == IDX_S1;
  assign sec_sel[1] = wr_en && wr_idx == IDX_S2;
  assign sec_sel[2] = wr_en && wr_idx == IDX_S3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= '0;
      msk_q <= '0;
    end else if (wr_en) begin
      if (wr_idx == IDX_PRI) pri_q <= wr_data[AW-1:1];
      if (wr_idx == IDX_MSK) msk_q <= wr_data[AW-1:1];
    end
  end

  assign match[0] = ~|((pc[AW-1:1] ^ pri_q) & ~msk_q);

  for (genvar i = 0; i < NSEC; i++) begin : g_sec
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sec_q[i] <= '0;
        sec_v[i] <= 1'b0;
      end else if (sec_sel[i]) begin
        sec_q[i] <= wr_data[AW-1:1];
        sec_v[i] <= wr_data[0];
      end
    end
    assign match[i+1] = sec_v[i] && (pc[AW-1:1] == sec_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit <= '0;
    else        hit <= pc_vld ? (match & cmp_en) : 4'b0;
  end

  assign any_hit = |hit;
endmodule

module pcbk_bank_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [4:0]    wr_idx,
  input logic          pc_vld,
  input logic [3:0]    cmp_en,
  input logic [3:0]    hit,
  input logic          any_hit,
  input logic [2:0]    sec_v,
  input logic [AW-1:1] pri_q,
  input logic [AW-1:1] msk_q
);
  logic listed;
  assign listed = wr_idx inside {5'h08, 5'h09, 5'h18, 5'h1A, 5'h1B};

  p_any_is_or_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit == (|hit));

  p_idle_no_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_vld |=> hit == 4'b0);

  p_enable_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (hit & ~$past(cmp_en)) == 4'b0);

  p_sec_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (hit[3:1] & ~$past(sec_v)) == 3'b0);

  p_unlisted_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !listed) |=> ($stable(sec_v) && $stable(pri_q) && $stable(msk_q)));
endmodule

bind pcbk_bank pcbk_bank_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
  .pc_vld(pc_vld), .cmp_en(cmp_en), .hit(hit), .any_hit(any_hit),
  .sec_v(sec_v), .pri_q(pri_q), .msk_q(msk_q)
);

// File: tb/sim_pcbk_bank.sv
module sim_pcbk_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] pc = '0;
  logic        pc_vld = 1'b0;
  logic [3:0]  cmp_en = '0;
  logic [3:0]  hit;
  logic        any_hit;

  int checks = 0;
  int failures = 0;

  logic [31:1] m_pri, m_msk;
  logic [31:1] m_sec [3];
  logic [2:0]  m_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcbk_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc(pc), .pc_vld(pc_vld), .cmp_en(cmp_en), .hit(hit), .any_hit(any_hit)
  );

  function automatic logic [3:0] expect_hit(logic [31:0] p, logic v, logic [3:0] en);
    logic [3:0] m;
    m[0] = ((p[31:1] ^ m_pri) & ~m_msk) == '0;
    for (int i = 0; i < 3; i++) m[i+1] = m_v[i] && (p[31:1] == m_sec[i]);
    return v ? (m & en) : 4'b0;
  endfunction

  task automatic model_write(logic [4:0] idx, logic [31:0] d);
    case (idx)
      5'h08: m_pri = d[31:1];
      5'h09: m_msk = d[31:1];
      5'h18: begin m_sec[0] = d[31:1]; m_v[0] = d[0]; end
      5'h1A: begin m_sec[1] = d[31:1]; m_v[1] = d[0]; end
      5'h1B: begin m_sec[2] = d[31:1]; m_v[2] = d[0]; end
      default: ;
    endcase
  endtask

  task automatic compare(string req, logic [3:0] e);
    checks++;
    if (hit !== e || any_hit !== (|e)) begin
      failures++;
      $display("FAIL %s: hit=%b any=%b expected hit=%b any=%b", req, hit, any_hit, e, |e);
    end
  endtask

  task automatic wr(logic [4:0] idx, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(idx, d);
  endtask

  task automatic chk(string req, logic [31:0] p, logic v, logic [3:0] en);
    logic [3:0] e;
    @(negedge clk);
    pc = p; pc_vld = v; cmp_en = en;
    e = expect_hit(p, v, en);
    @(negedge clk);
    pc_vld = 1'b0;
    compare(req, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] a, q;
    logic [3:0]  e;
    m_pri = '0; m_msk = '0; m_v = '0;
    for (int i = 0; i < 3; i++) m_sec[i] = '0;
    repeat (3) @(negedge clk);
    compare("R1 reset outputs", 4'b0);
    rst_n = 1'b1;
    chk("R1 reset primary zero", 32'h0, 1'b1, 4'hF);
    chk("R1 reset primary pc bit0", 32'h1, 1'b1, 4'hF);
    chk("R1 reset no secondary", 32'h0000_1000, 1'b1, 4'hF);

    a = 32'h1234_5678;
    wr(5'h18, a | 32'h1);
    wr(5'h1A, (a + 32'h10) | 32'h1);
    wr(5'h1B, (a + 32'h20) | 32'h1);
    wr(5'h08, a + 32'h30);
    chk("R2 primary index", a + 32'h30, 1'b1, 4'hF);
    chk("R2 sec1 index", a, 1'b1, 4'hF);
    chk("R2 sec2 index", a + 32'h10, 1'b1, 4'hF);
    chk("R2 sec3 index", a + 32'h20, 1'b1, 4'hF);
    chk("R3 pc bit0 ignored", a | 32'h1, 1'b1, 4'hF);

    q = 32'hA5C3_0F1E;
    wr(5'h08, q);
    for (int b = 1; b < 32; b++) begin
      wr(5'h09, 32'h1 << b);
      chk("R3 masked bit ignored", q ^ (32'h1 << b), 1'b1, 4'h1);
      wr(5'h09, 32'h0);
      chk("R3 unmasked bit compared", q ^ (32'h1 << b), 1'b1, 4'h1);
    end
    wr(5'h09, 32'hFFFF_FFFF);
    chk("R3 full mask any pc", 32'h0BAD_F00C, 1'b1, 4'h1);

    wr(5'h08, 32'h0000_4001);
    wr(5'h09, 32'h0);
    chk("R4 data bit0 discarded", 32'h0000_4000, 1'b1, 4'h1);
    chk("R4 disabled primary", 32'h0000_4000, 1'b1, 4'hE);

    wr(5'h09, 32'hFFFF_FFFF);
    for (int b = 1; b < 32; b++)
      chk("R5 secondary exact unaffected by mask", a ^ (32'h1 << b), 1'b1, 4'hE);
    wr(5'h18, a);
    chk("R5 cleared valid", a, 1'b1, 4'hF);
    wr(5'h09, 32'h0);

    chk("R6 pc_vld low", a + 32'h10, 1'b0, 4'hF);
    chk("R6 enable low", a + 32'h10, 1'b1, 4'h0);
    chk("R7 any_hit single", a + 32'h20, 1'b1, 4'h8);

    for (int idx = 0; idx < 32; idx++) begin
      if (!(idx inside {8, 9, 24, 26, 27})) wr(5'(idx), 32'hFFFF_FFFF);
    end
    chk("R8 unlisted writes keep primary", 32'h0000_4000, 1'b1, 4'hF);
    chk("R8 unlisted writes keep secondary", a + 32'h20, 1'b1, 4'hF);
    chk("R8 unlisted writes keep mask", 32'hFFFF_FFFE, 1'b1, 4'hF);

    q = 32'h7777_0000;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'h1A; wr_data = q | 32'h1;
    pc = q; pc_vld = 1'b1; cmp_en = 4'hF;
    e = expect_hit(q, 1'b1, 4'hF);
    @(negedge clk);
    wr_en = 1'b0; pc_vld = 1'b0;
    compare("R9 same-cycle write uses old contents", e);
    model_write(5'h1A, q | 32'h1);
    chk("R9 new contents next sample", q, 1'b1, 4'hF);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      case (n % 5)
        0: wr(5'h08, r);
        1: wr(5'h09, r & 32'h0000_00F0);
        2: wr(5'h18, r);
        3: wr(5'h1A, r);
        default: wr(5'h1B, r);
      endcase
      chk("R6 random near match", r ^ (32'h1 << (n % 8)), 1'(n % 3 != 0), 4'($urandom));
      chk("R7 random exact", r, 1'b1, 4'hF);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule